// File: doc/BRIEF.md
# Polar Code Butterfly Encoder

This block turns an 8-bit polar input vector into an 8-bit codeword. Before any arithmetic, every index marked as frozen in a static mask is forced to zero, so that position carries no information, exactly as a matching decoder assumes. The surviving bits then pass through three stages of XOR butterflies. The network is laid out with its input rails in bit-reversed index order, and its output rails are read back through the same reversal. The result equals the masked vector multiplied over GF(2) by the threefold Kronecker power of the 2x2 kernel [[1,0],[1,1]].

A word is presented with a valid strobe. The codeword appears in a register one clock later with its own valid flag. When no word is offered, the register keeps its last codeword. The code length is set by a log2 parameter, which defaults to 3 (n = 8).

Top module: `polar_bfly_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `cwValid` is 0 and `codeword` is all zeros.
- R2: Let u' = `uIn` & ~`frozenMask`, where bit i of `uIn` is input index i. One clock edge after `inValid` is high, bit j of `codeword` equals the XOR of all u'[i] for which (i & j) == j, over the indices i in 0..n-1.
- R3: Bits of `uIn` at indices where `frozenMask` is 1 have no effect on `codeword`.
- R4: `cwValid` is high in the cycle after a cycle with `inValid` high, and low in the cycle after a cycle with `inValid` low.
- R5: After a cycle with `inValid` low, `codeword` keeps its previous value.
- R6: Two edge cases hold. Codeword bit n-1 equals u'[n-1]. Codeword bit 0 equals the parity of all bits of u'.
- R7: With every bit of `frozenMask` set, the codeword produced for a valid input is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A new input vector is present on `uIn` |
| uIn | input | 8 | Input vector, bit i = index i |
| frozenMask | input | 8 | Static mask, bit i = 1 marks index i frozen |
| cwValid | output | 1 | `codeword` holds the result of the last accepted vector |
| codeword | output | 8 | Registered codeword, bit j = codeword index j |

## Verification
Both `codeword` and `cwValid` are due at the first rising edge after the cycle in which `inValid` is sampled high. The butterfly network has no register inside it, so no result arrives later than that edge. The bench drives inputs on a falling edge and samples the outputs on the next falling edge, which lies half a period after the edge that loads the result. A held codeword or a dropped valid flag is checked one falling edge after `inValid` is removed.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

  typedef struct packed {
    logic load;
  } encStrobe_t;

  function automatic int bitRev(input int idx, input int width);
    int r;
    r = 0;
    for (int b = 0; b < width; b++) begin
      if (((idx >> b) & 1) != 0) r = r | (1 << (width - 1 - b));
    end
    return r;
  endfunction

endpackage

// File: rtl/polar_enc_ctrl.sv
module polar_enc_ctrl
  import polar_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output encStrobe_t strobes,
  output logic       cwValid
);

  always_comb begin
    strobes.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cwValid <= 1'b0;
    else       cwValid <= inValid;
  end

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> cwValid);
  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !cwValid);

endmodule

// File: rtl/polar_enc_dp.sv
module polar_enc_dp
  import polar_enc_pkg::*;
#(
  parameter int LOG_N = 3,
  localparam int N = 1 << LOG_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  encStrobe_t   strobes,
  input  logic [N-1:0] uIn,
  input  logic [N-1:0] frozenMask,
  output logic [N-1:0] codeword
);

  logic [N-1:0] masked;
  logic [N-1:0] rail [LOG_N+1];
  logic [N-1:0] cwNext;
  logic [N-1:0] cwReg;

  assign masked = uIn & ~frozenMask;

  // Input rails carry indices in bit-reversed order.
  for (genvar r = 0; r < N; r++) begin : g_inRail
    localparam int SRC = bitRev(r, LOG_N);
    assign rail[0][r] = masked[SRC];
  end

  // XOR butterfly stages, span doubling per stage.
  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    localparam int SPAN = 1 << s;
    for (genvar j = 0; j < N; j++) begin : g_node
      if ((j & SPAN) == 0) begin : g_upper
        assign rail[s+1][j] = rail[s][j] ^ rail[s][j+SPAN];
      end else begin : g_lower
        assign rail[s+1][j] = rail[s][j];
      end
    end
  end

  // Output rails read back through the same reversal.
  for (genvar j = 0; j < N; j++) begin : g_outRail
    localparam int SRC = bitRev(j, LOG_N);
    assign cwNext[j] = rail[LOG_N][SRC];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cwReg <= '0;
    else if (strobes.load) cwReg <= cwNext;
  end

  assign codeword = cwReg;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(codeword));
  assert_top_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> codeword[N-1] == ($past(uIn[N-1]) & ~$past(frozenMask[N-1])));
  assert_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> codeword[0] == ^($past(uIn) & ~$past(frozenMask)));
  assert_all_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && (&frozenMask)) |=> codeword == '0);

endmodule

// File: rtl/polar_bfly_enc.sv
module polar_bfly_enc
  import polar_enc_pkg::*;
#(
  parameter int LOG_N = 3,
  localparam int N = 1 << LOG_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [N-1:0] uIn,
  input  logic [N-1:0] frozenMask,
  output logic         cwValid,
  output logic [N-1:0] codeword
);

  encStrobe_t strobes;

  polar_enc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .cwValid (cwValid)
  );

  polar_enc_dp #(.LOG_N(LOG_N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .uIn        (uIn),
    .frozenMask (frozenMask),
    .codeword   (codeword)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (!cwValid && codeword == '0));

endmodule

// File: tb/polar_bfly_enc_tb.sv
module polar_bfly_enc_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] uIn = '0;
  logic [7:0] frozenMask = '0;
  logic       cwValid;
  logic [7:0] codeword;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  polar_bfly_enc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .uIn(uIn),
    .frozenMask(frozenMask), .cwValid(cwValid), .codeword(codeword)
  );

  // {u, mask, expected codeword}
  localparam logic [23:0] VEC [10] = '{
    {8'h01, 8'h00, 8'h01},
    {8'h80, 8'h00, 8'hFF},
    {8'h02, 8'h00, 8'h03},
    {8'h10, 8'h00, 8'h11},
    {8'h08, 8'h00, 8'h0F},
    {8'hFF, 8'h00, 8'h80},
    {8'h96, 8'h00, 8'hE8},
    {8'hFF, 8'h80, 8'h7F},
    {8'hA5, 8'h0F, 8'hCC},
    {8'h5A, 8'hFF, 8'h00}
  };

  function automatic logic [7:0] refEnc(input logic [7:0] u, input logic [7:0] m);
    logic [7:0] v;
    logic [7:0] x;
    v = u & ~m;
    x = '0;
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++)
        if ((i & j) == j) x[j] = x[j] ^ v[i];
    return x;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] u, input logic [7:0] m);
    @(negedge clk);
    uIn = u; frozenMask = m; inValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'b0, cwValid}, 8'h00);
    check("R1 codeword in reset", codeword, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {7'b0, cwValid}, 8'h00);
    check("R1 codeword after release", codeword, 8'h00);

    // Table walk: R2 main function, R6/R7 corners
    for (int k = 0; k < 10; k++) begin
      apply(VEC[k][23:16], VEC[k][15:8]);
      check("R2 table codeword", codeword, VEC[k][7:0]);
      check("R4 valid after input", {7'b0, cwValid}, 8'h01);
    end

    // R2: full input sweep with a mixed mask against reference
    for (int u = 0; u < 256; u++) begin
      apply(8'(u), 8'h17);
      check("R2 sweep", codeword, refEnc(8'(u), 8'h17));
    end

    // R6: top bit and parity corners
    apply(8'h80, 8'h00);
    check("R6 top bit set", {7'b0, codeword[7]}, 8'h01);
    apply(8'h7F, 8'h00);
    check("R6 top bit clear", {7'b0, codeword[7]}, 8'h00);
    check("R6 parity bit0", {7'b0, codeword[0]}, 8'h01);

    // R3: frozen positions ignored
    apply(8'h00, 8'h5A);
    check("R3 frozen zero input", codeword, 8'h00);
    apply(8'h5A, 8'h5A);
    check("R3 frozen bits ignored", codeword, 8'h00);
    apply(8'hC3, 8'h3C);
    check("R3 base", codeword, refEnc(8'hC3, 8'h00));
    apply(8'hFF, 8'h3C);
    check("R3 frozen toggled", codeword, refEnc(8'hC3, 8'h00));

    // R7: all frozen
    apply(8'hFF, 8'hFF);
    check("R7 all frozen", codeword, 8'h00);

    // R5 hold and R4 valid drop
    apply(8'h96, 8'h00);
    check("R2 before hold", codeword, 8'hE8);
    inValid = 1'b0;
    uIn = 8'h01;
    @(negedge clk);
    check("R4 valid drops", {7'b0, cwValid}, 8'h00);
    check("R5 codeword held", codeword, 8'hE8);
    @(negedge clk);
    check("R5 still held", codeword, 8'hE8);

    // R1: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears codeword", codeword, 8'h00);
    rstN = 1'b1;

    done = 1'b1;
    finishRun();
  end

endmodule